// File: doc/BRIEF.md
# Prioritized Multifunction Shift Register

This block is a clocked register of parameterizable width that can hold its value, take a parallel word, shift one place toward the most significant end with a serial bit entering at the bottom, or be forced to all zeros or all ones. Four independent strobes request these operations. A fixed priority picks exactly one of them at each rising clock edge: zero-fill wins over one-fill, one-fill wins over parallel load, and parallel load wins over the shift.

The strobes are first folded into a 3-bit operation code. That code drives a per-bit 8-way chooser, and every bit of the register updates from the same code. Codes that no strobe combination produces are treated as hold. A separate synchronous reset input clears the contents at power-up. It is independent of the functional zero-fill strobe.

Top module: `prio_shift_reg`

## Requirements
- R1: While `rst` is high at a rising edge, the contents become all zeros on that edge, whatever the strobes are.
- R2: With no strobe asserted, the contents stay unchanged across the edge.
- R3: With `zap` high, the contents become all zeros on the edge, whatever `fill`, `ld` and `shl` are.
- R4: With `fill` high and `zap` low, the contents become all ones, whatever `ld` and `shl` are.
- R5: With `ld` high and `zap` and `fill` low, the contents become `din`, whatever `shl` is.
- R6: With only `shl` asserted among the strobes, bit n takes the old bit n-1 and bit 0 takes `sin`.
- R7: The internal operation code is 000 for hold, 001 for load, 010 for shift, 011 for zero-fill and 100 for one-fill. Codes 101 to 111 hold. The code is always one of the five used values.
- R8: Changes on `din`, `sin` or any strobe between rising edges do not alter `q`. All updates happen only at the rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset to zero |
| zap | input | 1 | Clear-to-zero strobe (highest priority) |
| fill | input | 1 | Set-to-ones strobe |
| ld | input | 1 | Parallel load strobe |
| shl | input | 1 | Shift-left strobe (lowest priority) |
| sin | input | 1 | Serial bit entering bit 0 on a shift |
| din | input | W | Parallel data word |
| q | output | W | Register contents |

## Verification
On every cycle, the assertions check each operation's outcome against the previous cycle's strobes and contents, and they check that the operation code never takes an unused value. Only the bench's scenarios show three things: that all sixteen strobe combinations resolve in the right priority for distinct data and serial values, that repeated shifts march a serial pattern through the whole width, and that input changes between edges leave the output untouched.

// File: rtl/prio_shift_reg.sv
module prio_shift_reg #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         zap,
  input  logic         fill,
  input  logic         ld,
  input  logic         shl,
  input  logic         sin,
  input  logic [W-1:0] din,
  output logic [W-1:0] q
);
  logic [2:0]   op;
  logic [W-1:0] shifted;
  logic [W-1:0] nxt;

  assign op[2] = !zap & fill;
  assign op[1] = (!zap & !fill & !ld & shl) | zap;
  assign op[0] = (!zap & !fill & ld) | zap;

  if (W > 1) begin : g_wide
    assign shifted = {q[W-2:0], sin};
  end else begin : g_one
    assign shifted = sin;
  end

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_comb begin
      case (op)
        3'b001:  nxt[i] = din[i];
        3'b010:  nxt[i] = shifted[i];
        3'b011:  nxt[i] = 1'b0;
        3'b100:  nxt[i] = 1'b1;
        default: nxt[i] = q[i];
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= nxt;
  end
endmodule

module prio_shift_reg_chk #(
  parameter int W = 4
) (
  input logic         clk,
  input logic         rst,
  input logic         zap,
  input logic         fill,
  input logic         ld,
  input logic         shl,
  input logic         sin,
  input logic [W-1:0] din,
  input logic [W-1:0] q,
  input logic [2:0]   op
);
  logic [W:0] ext;
  assign ext = {q, sin};

  // R1
  reset_zero_chk: assert property (@(posedge clk) rst |=> q == '0);
  // R2
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!zap && !fill && !ld && !shl) |=> $stable(q));
  // R3
  zap_chk: assert property (@(posedge clk) disable iff (rst) zap |=> q == '0);
  // R4
  fill_chk: assert property (@(posedge clk) disable iff (rst)
    (fill && !zap) |=> q == '1);
  // R5
  load_chk: assert property (@(posedge clk) disable iff (rst)
    (ld && !zap && !fill) |=> q == $past(din));
  // R6
  shift_chk: assert property (@(posedge clk) disable iff (rst)
    (shl && !ld && !zap && !fill) |=> q == $past(ext[W-1:0]));
  // R7
  op_legal_chk: assert property (@(posedge clk) disable iff (rst) op <= 3'd4);
endmodule

bind prio_shift_reg prio_shift_reg_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .zap(zap), .fill(fill), .ld(ld), .shl(shl),
  .sin(sin), .din(din), .q(q), .op(op)
);

// File: tb/sim_prio_shift_reg.sv
module sim_prio_shift_reg;
  localparam int W = 4;
  logic clk = 0, rst = 1, zap = 0, fill = 0, ld = 0, shl = 0, sin = 0;
  logic [W-1:0] din = '0;
  logic [W-1:0] q;
  int errs = 0, checks = 0;
  bit done = 0;

  prio_shift_reg #(.W(W)) u0 (.*);

  always #5 clk = ~clk;

  task automatic chk(string req, logic [W-1:0] got, logic [W-1:0] exp);
    checks++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s: got %b expected %b", req, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic drive(logic z, logic f, logic l, logic s, logic si, logic [W-1:0] d);
    zap = z; fill = f; ld = l; shl = s; sin = si; din = d;
  endtask

  function automatic logic [W-1:0] model(logic [W-1:0] cur, logic [3:0] st,
                                         logic si, logic [W-1:0] d);
    if (st[3]) return '0;
    if (st[2]) return '1;
    if (st[1]) return d;
    if (st[0]) return {cur[W-2:0], si};
    return cur;
  endfunction

  task automatic t_reset();
    drive(0, 1, 1, 1, 1, 4'b1010);
    rst = 1; step(); chk("R1", q, '0);
    rst = 0; drive(0, 0, 0, 0, 0, '0); step(); chk("R2", q, '0);
  endtask

  task automatic t_all_combos();
    for (int pre = 0; pre < 2; pre++) begin
      for (int st = 0; st < 16; st++) begin
        logic [W-1:0] seed = pre ? 4'b0110 : 4'b1001;
        logic [W-1:0] d = 4'b0101 ^ W'(st);
        logic si = st[0] ^ pre[0];
        logic [W-1:0] exp;
        drive(0, 0, 1, 0, 0, seed); step();
        exp = model(seed, 4'(st), si, d);
        drive(st[3], st[2], st[1], st[0], si, d); step();
        if (st[3])      chk("R3", q, exp);
        else if (st[2]) chk("R4", q, exp);
        else if (st[1]) chk("R5", q, exp);
        else if (st[0]) chk("R6", q, exp);
        else            chk("R2 R7", q, exp);
      end
    end
    drive(0, 0, 0, 0, 0, '0);
  endtask

  task automatic t_shift_walk();
    logic [W-1:0] exp = 4'b0000;
    logic [7:0] pat = 8'b1101_0011;
    drive(1, 0, 0, 0, 0, '0); step();
    for (int i = 0; i < 8; i++) begin
      drive(0, 0, 0, 1, pat[i], 4'b1111); step();
      exp = {exp[W-2:0], pat[i]};
      chk("R6", q, exp);
    end
  endtask

  task automatic t_between_edges();
    logic [W-1:0] held;
    drive(0, 0, 1, 0, 0, 4'b1100); step();
    held = q; chk("R5", held, 4'b1100);
    @(negedge clk);
    drive(1, 1, 1, 1, 1, 4'b0011); #1;
    chk("R8", q, held);
    drive(0, 0, 0, 0, 0, 4'b0011); #1;
    chk("R8", q, held);
    step(); chk("R2", q, held);
  endtask

  initial begin
    t_reset();
    t_all_combos();
    t_shift_walk();
    t_between_edges();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule